// File: doc/BRIEF.md
# Asynchronous 16-bit SRAM Controller

This block sits between a clocked host and an external 128K x 16 asynchronous static RAM. The host offers one request at a time: a read or write flag, a 17-bit word address, 16 bits of write data and two active-high lane enables (bit 0 for data bits 7:0, bit 1 for bits 15:8). The controller turns each request into a timed sequence on the memory pins: chip select, output enable, write enable and two active-low lane strobes, a held address and a tri-state data bus.

Every phase lasts a whole number of clock cycles. Each count comes from a nanosecond minimum: the time is divided by the clock period, both given in picoseconds, and rounded up. The counts are fixed when the block is built. The state machine has six states. ST_IDLE accepts requests. ST_SKIP completes a request that has no lane enabled. ST_READ holds the read strobes. ST_WPULSE holds the write-enable low pulse. ST_WHOLD keeps the data driven for one cycle after write enable rises. ST_RECOVER holds every strobe high between accesses. The transitions are:

- ST_IDLE to ST_SKIP when the request has no lane enabled.
- ST_IDLE to ST_READ for a read.
- ST_IDLE to ST_WPULSE for a write.
- ST_READ to ST_RECOVER when its timer expires.
- ST_WPULSE to ST_WHOLD when its timer expires.
- ST_WHOLD to ST_RECOVER always.
- ST_SKIP to ST_IDLE always.
- ST_RECOVER to ST_IDLE when its timer expires.

With the default 20 ns clock, these counts apply:

- N_RD = 6 read cycles, from 120 ns access and 120 ns cycle.
- N_WP = 4 write-pulse cycles, from 80 ns pulse and 50 ns data setup.
- N_TA = 2 turnaround cycles, from 35 ns bus release.
- N_WREC = 2 write recovery cycles.

Top module: `sram16_ctrl`

## Requirements
- R1: After reset, and whenever `ready` is high, chip select, output enable and write enable are all high, both lane strobes are high and the controller does not drive `mem_dq`.
- R2: A read with at least one lane enabled holds chip select and output enable low and write enable high for N_RD cycles. Only the enabled lanes have their strobe low. In `rdata`, a disabled lane reads as zero.
- R3: A write with at least one lane enabled holds chip select and write enable low and output enable high. Only the enabled lanes have their strobe low. Only those lanes of the memory word change.
- R4: Write enable stays low for exactly N_WP = max(ceil(tWP/tCLK), ceil(tDW/tCLK)) cycles. Chip select and the lane strobes stay low for one further cycle (ST_WHOLD) after write enable rises.
- R5: The controller drives `mem_dq` with the write data only in ST_WPULSE and ST_WHOLD. It never drives the bus while output enable is low.
- R6: After every read or write, chip select stays high for a recovery phase before `ready` returns: N_TA cycles after a read and N_WREC cycles after a write.
- R7: While chip select is low, `mem_addr` and both lane strobes do not change.
- R8: A request with both lane enables at 0 toggles no strobe. Its completion pulse (`rvalid` for a read, `wdone` for a write) comes one cycle after acceptance, and `ready` returns in that same cycle.
- R9: `rvalid` and `wdone` are single-cycle pulses. `rvalid` rises N_RD cycles after the accepting edge. `wdone` rises N_WP+1 cycles after it.
- R10: A request is taken only on a clock edge where `ready` is high. A `req` held high while the controller is busy has no effect on the memory pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Host request, taken when ready is high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Word address |
| wdata | input | 16 | Write data |
| be | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ready | output | 1 | Controller idle and able to accept |
| rdata | output | 16 | Read data, disabled lanes zero |
| rvalid | output | 1 | One-cycle read completion |
| wdone | output | 1 | One-cycle write completion |
| mem_addr | output | 17 | Memory address |
| mem_dq | inout | 16 | Memory data bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |

## Verification
Take the accepting edge as cycle 0. For a read, the strobes are low in cycles 0 to 5 and `rvalid` with its data appears in cycle 6. `ready` returns in cycle 8. For a write, write enable is low in cycles 0 to 3 and high again in cycle 4 with chip select still low. `wdone` appears in cycle 5 and `ready` returns in cycle 7. A request with no lane enabled shows its pulse and `ready` in cycle 1. The bench keeps its own counter of cycles since acceptance. On every falling clock edge it compares all strobes, `ready` and both pulses with the values due in that cycle. In the same cycles it also checks the address, the driven bus and the read data.

// File: rtl/sram16_pkg.sv
package sram16_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKIP,
        ST_READ,
        ST_WPULSE,
        ST_WHOLD,
        ST_RECOVER
    } seq_state_e;

    // Round a time up to whole clock periods.
    function automatic int ps_to_cycles(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram16_tick.sv
// Down-counter that times one phase; last is high in the phase's final cycle.
module sram16_tick #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram16_iobuf.sv
// Tri-state pad driver for the memory data bus.
module sram16_iobuf #(
    parameter int DW = 16
) (
    inout  wire  [DW-1:0] pad,
    input  logic          drive,
    input  logic [DW-1:0] dout,
    output logic [DW-1:0] din
);
    assign pad = drive ? dout : {DW{1'bz}};
    assign din = pad;
endmodule

// File: rtl/sram16_seq.sv
module sram16_seq
    import sram16_pkg::*;
#(
    parameter int AW     = 17,
    parameter int DW     = 16,
    parameter int CW     = 3,
    parameter int N_RD   = 6,
    parameter int N_WP   = 4,
    parameter int N_TA   = 2,
    parameter int N_WREC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    be,
    output logic          ready,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          wdone,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_ub_n,
    output logic          mem_lb_n,
    output logic          dq_drive,
    output logic [DW-1:0] dq_out,
    input  logic [DW-1:0] dq_in,
    output logic          tick_load,
    output logic [CW-1:0] tick_val,
    input  logic          tick_last
);
    localparam int HALF = DW / 2;

    seq_state_e    state_q, state_d;
    logic          wr_q;
    logic [1:0]    be_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          accept;
    logic          lanes_on;

    assign accept = (state_q == ST_IDLE) && req;

    // Next-state and phase-timer loading.
    always_comb begin
        state_d   = state_q;
        tick_load = 1'b0;
        tick_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (be == 2'b00) begin
                        state_d = ST_SKIP;
                    end else if (wr) begin
                        state_d   = ST_WPULSE;
                        tick_load = 1'b1;
                        tick_val  = CW'(N_WP - 1);
                    end else begin
                        state_d   = ST_READ;
                        tick_load = 1'b1;
                        tick_val  = CW'(N_RD - 1);
                    end
                end
            end
            ST_SKIP: state_d = ST_IDLE;
            ST_READ: begin
                if (tick_last) begin
                    state_d   = ST_RECOVER;
                    tick_load = 1'b1;
                    tick_val  = CW'(N_TA - 1);
                end
            end
            ST_WPULSE: begin
                if (tick_last)
                    state_d = ST_WHOLD;
            end
            ST_WHOLD: begin
                state_d   = ST_RECOVER;
                tick_load = 1'b1;
                tick_val  = CW'(N_WREC - 1);
            end
            ST_RECOVER: begin
                if (tick_last)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Request capture: address and lanes stay fixed until the next accept.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            be_q    <= 2'b00;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= wr;
            be_q    <= be;
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    // Strobe outputs decoded from the state.
    always_comb begin
        mem_cs_n = 1'b1;
        mem_oe_n = 1'b1;
        mem_we_n = 1'b1;
        dq_drive = 1'b0;
        lanes_on = 1'b0;
        unique case (state_q)
            ST_READ: begin
                mem_cs_n = 1'b0;
                mem_oe_n = 1'b0;
                lanes_on = 1'b1;
            end
            ST_WPULSE: begin
                mem_cs_n = 1'b0;
                mem_we_n = 1'b0;
                dq_drive = 1'b1;
                lanes_on = 1'b1;
            end
            ST_WHOLD: begin
                mem_cs_n = 1'b0;
                dq_drive = 1'b1;
                lanes_on = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_lb_n = !(lanes_on && be_q[0]);
    assign mem_ub_n = !(lanes_on && be_q[1]);
    assign mem_addr = addr_q;
    assign dq_out   = wdata_q;
    assign ready    = (state_q == ST_IDLE);

    // Completion pulses and read capture at the end of the read phase.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            wdone  <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= ((state_q == ST_READ) && tick_last) || ((state_q == ST_SKIP) && !wr_q);
            wdone  <= (state_q == ST_WHOLD) || ((state_q == ST_SKIP) && wr_q);
            if ((state_q == ST_READ) && tick_last)
                rdata <= {be_q[1] ? dq_in[DW-1:HALF] : {HALF{1'b0}},
                          be_q[0] ? dq_in[HALF-1:0]  : {HALF{1'b0}}};
            else if (state_q == ST_SKIP)
                rdata <= '0;
        end
    end

    // Width of each write-enable low pulse, for the pulse check below.
    int unsigned we_low_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            we_low_cnt <= 0;
        else if (!mem_we_n)
            we_low_cnt <= we_low_cnt + 1;
        else
            we_low_cnt <= 0;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !dq_drive));
    a_r3_write_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n));
    a_r4_wp_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt == N_WP && !mem_cs_n));
    a_r5_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> mem_oe_n);
    a_r6_recover: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) |-> !ready);
    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable({mem_ub_n, mem_lb_n})));
    a_r9_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);
    a_r9_wdone_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wdone |=> !wdone);
endmodule

// File: rtl/sram16_ctrl.sv
module sram16_ctrl
    import sram16_pkg::*;
#(
    parameter int AW      = 17,
    parameter int CLK_PS  = 20000,
    parameter int T_AA_PS = 120000,
    parameter int T_RC_PS = 120000,
    parameter int T_WP_PS = 80000,
    parameter int T_DW_PS = 50000,
    parameter int T_HZ_PS = 35000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    input  logic [1:0]    be,
    output logic          ready,
    output logic [15:0]   rdata,
    output logic          rvalid,
    output logic          wdone,
    output logic [AW-1:0] mem_addr,
    inout  wire  [15:0]   mem_dq,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_ub_n,
    output logic          mem_lb_n
);
    localparam int DW     = 16;
    localparam int N_RD   = max2(ps_to_cycles(T_AA_PS, CLK_PS), ps_to_cycles(T_RC_PS, CLK_PS));
    localparam int N_WP   = max2(ps_to_cycles(T_WP_PS, CLK_PS), ps_to_cycles(T_DW_PS, CLK_PS));
    localparam int N_TA   = max2(1, ps_to_cycles(T_HZ_PS, CLK_PS));
    localparam int N_WC   = ps_to_cycles(T_RC_PS, CLK_PS);
    localparam int N_WREC = max2(N_TA, N_WC - N_WP - 1);
    localparam int N_MAX  = max2(max2(N_RD, N_WP), N_WREC);
    localparam int CW     = $clog2(N_MAX + 1);

    logic          dq_drive;
    logic [DW-1:0] dq_out;
    logic [DW-1:0] dq_in;
    logic          tick_load;
    logic [CW-1:0] tick_val;
    logic          tick_last;

    sram16_seq #(
        .AW(AW), .DW(DW), .CW(CW),
        .N_RD(N_RD), .N_WP(N_WP), .N_TA(N_TA), .N_WREC(N_WREC)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .wdata(wdata), .be(be), .ready(ready), .rdata(rdata),
        .rvalid(rvalid), .wdone(wdone), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .dq_drive(dq_drive),
        .dq_out(dq_out), .dq_in(dq_in), .tick_load(tick_load),
        .tick_val(tick_val), .tick_last(tick_last)
    );

    sram16_tick #(.CW(CW)) i_tick (
        .clk(clk), .rst_n(rst_n), .load(tick_load),
        .load_val(tick_val), .last(tick_last)
    );

    sram16_iobuf #(.DW(DW)) i_iobuf (
        .pad(mem_dq), .drive(dq_drive), .dout(dq_out), .din(dq_in)
    );
endmodule

// File: tb/test_sram16_ctrl.sv
`timescale 1ns/1ps
module test_sram16_ctrl;
    localparam int TCLK = 20;
    localparam int C_RD   = (120 + TCLK - 1) / TCLK;              // 6
    localparam int C_WP   = (80 + TCLK - 1) / TCLK;               // 4
    localparam int C_TA   = (35 + TCLK - 1) / TCLK;               // 2
    localparam int C_WREC = (C_TA > C_RD - C_WP - 1) ? C_TA : C_RD - C_WP - 1;
    localparam int LEN_RD = C_RD + C_TA;
    localparam int LEN_WR = C_WP + 1 + C_WREC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, wr = 1'b0;
    logic [16:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  be = 2'b00;
    logic ready, rvalid, wdone;
    logic [15:0] rdata;
    logic [16:0] mem_addr;
    wire  [15:0] mem_dq;
    logic mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;

    int n_tests = 0, n_fail = 0, cyc = 0;

    always #(TCLK/2) clk = ~clk;

    sram16_ctrl i_sram16_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .wdata(wdata), .be(be), .ready(ready), .rdata(rdata),
        .rvalid(rvalid), .wdone(wdone), .mem_addr(mem_addr), .mem_dq(mem_dq),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n)
    );

    // Behavioural memory.
    logic [15:0] marr [logic [16:0]];
    logic [15:0] mrd;
    always @(mem_addr or mem_oe_n or mem_cs_n or mem_we_n)
        mrd = marr.exists(mem_addr) ? marr[mem_addr] : 16'h0000;
    assign mem_dq[7:0]  = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_lb_n) ? mrd[7:0]  : 8'hzz;
    assign mem_dq[15:8] = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_ub_n) ? mrd[15:8] : 8'hzz;
    always @(posedge mem_we_n) begin
        if (!mem_cs_n) begin
            logic [15:0] cur;
            cur = marr.exists(mem_addr) ? marr[mem_addr] : 16'h0000;
            if (!mem_lb_n) cur[7:0]  = mem_dq[7:0];
            if (!mem_ub_n) cur[15:8] = mem_dq[15:8];
            marr[mem_addr] = cur;
        end
    end

    // Reference model: kind 1 read, 2 write, 3 no-lane request.
    logic [15:0] shadow [logic [16:0]];
    int m_busy = 0, m_t = 0, m_kind = 0, m_len = 0;
    logic m_wr = 1'b0;
    logic [1:0] m_be = 2'b00;
    logic [16:0] m_addr = '0;
    logic [15:0] m_wd = '0;
    logic e_rv = 1'b0, e_wd = 1'b0;

    always @(posedge clk) begin
        e_rv = 1'b0;
        e_wd = 1'b0;
        if (!rst_n) begin
            m_busy = 0;
        end else if (m_busy != 0) begin
            if (m_t + 1 == m_len) begin
                m_busy = 0;
                if (m_kind == 3) begin
                    e_rv = !m_wr;
                    e_wd = m_wr;
                end
            end else begin
                m_t++;
            end
            if (m_kind == 1 && m_t == C_RD && m_busy != 0) e_rv = 1'b1;
            if (m_kind == 2 && m_t == C_WP + 1 && m_busy != 0) e_wd = 1'b1;
        end else if (req) begin
            m_busy = 1; m_t = 0;
            m_wr = wr; m_be = be; m_addr = addr; m_wd = wdata;
            if (be == 2'b00) begin
                m_kind = 3; m_len = 1;
            end else if (wr) begin
                logic [15:0] s;
                m_kind = 2; m_len = LEN_WR;
                s = shadow.exists(addr) ? shadow[addr] : 16'h0000;
                if (be[0]) s[7:0]  = wdata[7:0];
                if (be[1]) s[15:8] = wdata[15:8];
                shadow[addr] = s;
            end else begin
                m_kind = 1; m_len = LEN_RD;
            end
        end
    end

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] exp_v, act_v;
            logic cs, oe, we, ln;
            string tag;
            cs = 1; oe = 1; we = 1; ln = 0;
            tag = "R1";
            if (m_busy != 0 && m_kind == 1) begin
                tag = (m_t < C_RD) ? "R2" : "R6";
                if (m_t < C_RD) begin cs = 0; oe = 0; ln = 1; end
            end else if (m_busy != 0 && m_kind == 2) begin
                tag = (m_t <= C_WP) ? "R4" : "R6";      // R3 strobes, R4 pulse length
                if (m_t < C_WP) begin cs = 0; we = 0; ln = 1; end
                else if (m_t == C_WP) begin cs = 0; ln = 1; end
            end else if (m_busy != 0) begin
                tag = "R8";
            end
            exp_v = {(m_busy == 0), cs, oe, we, !(ln && m_be[1]), !(ln && m_be[0]), e_rv, e_wd};
            act_v = {ready, mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, rvalid, wdone};
            if (exp_v[1:0] != act_v[1:0]) tag = "R9";
            n_tests++;
            if (act_v !== exp_v) begin
                n_fail++;
                $display("FAIL %s strobes {rdy,cs,oe,we,ub,lb,rv,wd} got %b exp %b (t=%0d)", tag, act_v, exp_v, m_t);
            end
            if (!cs) begin
                n_tests++;
                if (mem_addr !== m_addr) begin
                    n_fail++;
                    $display("FAIL R7 mem_addr got %h exp %h", mem_addr, m_addr);
                end
            end
            if (m_busy != 0 && m_kind == 2 && m_t <= C_WP) begin
                n_tests++;
                if (mem_dq !== m_wd) begin
                    n_fail++;
                    $display("FAIL R5 write bus got %h exp %h", mem_dq, m_wd);
                end
            end
            if (e_rv) begin
                logic [15:0] s, x;
                s = shadow.exists(m_addr) ? shadow[m_addr] : 16'h0000;
                x = {m_be[1] ? s[15:8] : 8'h00, m_be[0] ? s[7:0] : 8'h00};
                n_tests++;
                if (rdata !== x) begin
                    n_fail++;
                    $display("FAIL R2 rdata got %h exp %h", rdata, x);
                end
            end
        end
    end

    task automatic access(input logic w, input logic [16:0] a, input logic [15:0] d, input logic [1:0] b);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d; be = b;
        @(posedge clk);
        #1 req = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_tests++; n_fail++;
            $display("FAIL R9 watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_tests++;   // R1 reset state
        if ({ready, mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, rvalid, wdone} !== 8'b1111_1100
            || mem_dq !== 16'hzzzz) begin
            n_fail++;
            $display("FAIL R1 reset outputs got %b exp 11111100",
                     {ready, mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, rvalid, wdone});
        end
        rst_n = 1'b1;
        access(1, 17'h00012, 16'hA55A, 2'b11);   // R3 word write
        access(0, 17'h00012, 16'h0000, 2'b11);   // R2 word read
        access(1, 17'h1FFFF, 16'h1234, 2'b11);
        access(1, 17'h1FFFF, 16'hBEEF, 2'b01);   // R3 lower lane only
        access(0, 17'h1FFFF, 16'h0000, 2'b11);   // expect 12EF
        access(1, 17'h1FFFF, 16'hC0DE, 2'b10);   // R3 upper lane only
        access(0, 17'h1FFFF, 16'h0000, 2'b01);   // R2 lower-lane read
        access(0, 17'h1FFFF, 16'h0000, 2'b10);   // R2 upper-lane read
        access(1, 17'h00012, 16'hFFFF, 2'b00);   // R8 no-lane write
        access(0, 17'h00012, 16'h0000, 2'b00);   // R8 no-lane read
        access(0, 17'h00012, 16'h0000, 2'b11);   // still A55A
        access(1, 17'h0AAAA, 16'h5678, 2'b11);   // R5 write then read back-to-back
        access(0, 17'h0AAAA, 16'h0000, 2'b11);
        // R10: req held high while busy has no effect.
        access(0, 17'h00012, 16'h0000, 2'b11);
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 17'h00012; wdata = 16'h0BAD; be = 2'b11;
        repeat (3) @(negedge clk);
        req = 1'b0;
        access(0, 17'h00012, 16'h0000, 2'b11);   // must still read A55A
        access(0, 17'h05555, 16'h0000, 2'b11);   // unwritten word reads 0
        repeat (12) @(negedge clk);
        finish_run();
    end
endmodule